// File: doc/BRIEF.md
# Delta-Sigma I/Q Bit-Stream Transmitter

This block is a transmit datapath with no multipliers and no numeric oscillator. It takes signed baseband samples for the in-phase and quadrature paths and turns each into a one-bit stream. Each path has its own second-order error-feedback delta-sigma loop. Plain bit selection then moves the two streams up to a carrier at fc = N·fs and merges them into one bi-level line. That line is meant to drive a switching power amplifier directly. The out-of-band quantisation noise is left for an external band-pass filter.

The block runs on a fast clock at four times the carrier rate, so one carrier period is four clocks. Within each period the output carries the I bit, the Q bit, the inverted I bit and the inverted Q bit, in that order. The inversion inside each branch switches at twice the carrier rate. The merge between the branches switches on every clock. The block produces a sample strobe once every 4·N clocks, and the source presents a new I/Q pair against that strobe. Each captured pair is held for N carrier periods, and each modulator takes one step per carrier period. The divide ratio N is programmable and changes only at a sample boundary.

Top module: `dsm_iq_tx`

## Requirements
- R1: While reset is high, `rf_out` and `smp_stb` are 0. After reset, `rf_out` stays 0 until a sample has been captured with `smp_vld` high, even while strobes keep occurring.
- R2: `smp_stb` is high for exactly one clock, once every 4·N clocks, where N is the ratio currently in effect. For example, N=1 gives 4 clocks, N=3 gives 12 and N=64 gives 256.
- R3: A new value on `ratio_n` does not alter the sample interval already in progress. It is loaded in the clock where `smp_stb` is high and governs the interval that starts after that clock.
- R4: A `ratio_n` of 0 acts as N=1. Any value above 64 acts as N=64.
- R5: If `smp_stb` is high in clock t, then clocks t+2, t+3, t+4 and t+5 carry, on `rf_out`, the I bit, the Q bit, the inverse of the I bit and the inverse of the Q bit of the same carrier period. This four-clock pattern repeats in every carrier period.
- R6: `i_smp` and `q_smp` are captured only on the clock edge that ends a clock with `smp_stb` high while `smp_vld` is high. Input values at any other time, or with `smp_vld` low, do not affect the output.
- R7: An I bit of 1 stands for +32768 and an I bit of 0 stands for −32768. For a constant 16-bit two's-complement I input with magnitude up to 16384, the mean of the I bits over 3000 carrier periods lies within 328 (1 % of full scale) of the input.
- R8: The Q bits meet the same mean-tracking bound for a constant Q input, independently of the value on the I path.
- R9: Suppose a path's input is −32768 from the first capture after reset. That path's bit is then 0 in every carrier period: the modulator's accumulated state never builds up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bit clock, four clocks per carrier period |
| rst | input | 1 | Synchronous reset, active high |
| i_smp | input | 16 | In-phase sample, signed two's complement |
| q_smp | input | 16 | Quadrature sample, signed two's complement |
| smp_vld | input | 1 | Marks the presented I/Q pair as valid for capture at the strobe |
| ratio_n | input | 7 | Carrier-to-sample-rate ratio N, valid range 1 to 64 |
| smp_stb | output | 1 | One-clock pulse in the last clock of each sample interval |
| rf_out | output | 1 | Bi-level carrier-rate output to the power amplifier |

## Verification
The hardest case to reach from the ports is proving that only the value present at the strobe is captured. The modulator turns any sample into a long bit sequence, so a single wrong capture disappears into noise. To expose it, the bench sets N=4 and rewrites the inputs on every clock. One pair is driven during the strobe clock, and a different pair, far from it, is driven in every other clock. The mean of thousands of demodulated bits then shows clearly which pair the block held. The exact-zero behaviour at the most negative code only holds from a clean loop state, so that case is run straight after a reset.

// File: rtl/dsm_iq_pkg.sv
package dsm_iq_pkg;

   // Output slot within one carrier period (four fast clocks).
   typedef enum logic [1:0] {
      SLOT_I    = 2'd0,
      SLOT_Q    = 2'd1,
      SLOT_IBAR = 2'd2,
      SLOT_QBAR = 2'd3
   } slot_e;

   localparam int unsigned BRANCHES = 2;

   // Symmetric clipping to +/- lim.
   function automatic logic signed [31:0] clip32(input logic signed [31:0] val,
                                                 input logic signed [31:0] lim);
      if (val > lim)       return lim;
      else if (val < -lim) return -lim;
      else                 return val;
   endfunction

endpackage

// File: rtl/dsm_iq_seq.sv
module dsm_iq_seq
   import dsm_iq_pkg::*;
#(
   parameter int unsigned N_MAX = 64,
   parameter int unsigned N_W   = 7
)(
   input  logic           clk,
   input  logic           rst,
   input  logic [N_W-1:0] ratio_n,
   output slot_e          slot,
   output logic           car_end,
   output logic           smp_bnd,
   output logic [N_W-1:0] n_cur
);

   localparam int unsigned CNT_W = (N_MAX > 1) ? $clog2(N_MAX) : 1;
   localparam logic [N_W-1:0] N_TOP = N_W'(N_MAX);

   generate
      if (N_MAX < 1) begin : g_bad_nmax
         $error("dsm_iq_seq: N_MAX must be at least 1");
      end
      if ($clog2(N_MAX + 1) > N_W) begin : g_bad_nw
         $error("dsm_iq_seq: N_W too narrow for N_MAX");
      end
      if (CNT_W > N_W) begin : g_bad_cnt
         $error("dsm_iq_seq: counter wider than ratio field");
      end
   endgenerate

   logic [CNT_W-1:0] per_cnt;
   logic [N_W-1:0]   n_next;

   // Out-of-range ratios are clamped into 1..N_MAX.
   always_comb begin
      if (ratio_n == '0)         n_next = N_W'(1);
      else if (ratio_n > N_TOP)  n_next = N_TOP;
      else                       n_next = ratio_n;
   end

   assign car_end = (slot == SLOT_QBAR);
   assign smp_bnd = car_end && (N_W'(per_cnt) == (n_cur - N_W'(1)));

   always_ff @(posedge clk) begin
      if (rst) begin
         slot    <= SLOT_I;
         per_cnt <= '0;
         n_cur   <= n_next;
      end else begin
         slot <= slot_e'(slot + 2'd1);
         if (smp_bnd) begin
            per_cnt <= '0;
            n_cur   <= n_next;
         end else if (car_end) begin
            per_cnt <= per_cnt + CNT_W'(1);
         end
      end
   end

endmodule

// File: rtl/dsm_iq_mod.sv
module dsm_iq_mod
   import dsm_iq_pkg::*;
#(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned ACC_W  = 20,
   parameter bit          SAT_EN = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst,
   input  logic                   step,
   input  logic signed [IN_W-1:0] x,
   output logic                   bit_q
);

   localparam logic signed [31:0] FS  = 32'sd1 <<< (IN_W - 1);
   localparam logic signed [31:0] LIM = (32'sd1 <<< (ACC_W - 1)) - 32'sd1;

   generate
      if (IN_W < 2 || IN_W > 24) begin : g_bad_in
         $error("dsm_iq_mod: IN_W out of range 2..24");
      end
      if (ACC_W < IN_W + 3 || ACC_W > 30) begin : g_bad_acc
         $error("dsm_iq_mod: ACC_W must be IN_W+3 .. 30");
      end
   endgenerate

   // Quantisation errors of the two previous steps.
   logic signed [ACC_W-1:0] e1, e2;
   logic signed [31:0]      xw, e1w, e2w, v_raw, v_use, y_val, e_use;
   logic                    y_bit;

   // Noise shaping (1 - z^-1)^2: v = x - 2*e[n-1] + e[n-2].
   always_comb begin
      xw    = 32'(x);
      e1w   = 32'(e1);
      e2w   = 32'(e2);
      v_raw = xw - (e1w <<< 1) + e2w;
   end

   generate
      if (SAT_EN) begin : g_sat
         always_comb begin
            v_use = clip32(v_raw, LIM);
            y_bit = ~v_use[31];
            y_val = y_bit ? FS : -FS;
            e_use = clip32(y_val - v_use, LIM);
         end
      end else begin : g_wrap
         always_comb begin
            v_use = 32'(ACC_W'(v_raw));
            y_bit = ~v_use[31];
            y_val = y_bit ? FS : -FS;
            e_use = 32'(ACC_W'(y_val - v_use));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         e1    <= '0;
         e2    <= '0;
         bit_q <= 1'b0;
      end else if (step) begin
         e2    <= e1;
         e1    <= ACC_W'(e_use);
         bit_q <= y_bit;
      end
   end

endmodule

// File: rtl/dsm_iq_mux.sv
module dsm_iq_mux
   import dsm_iq_pkg::*;
(
   input  logic                clk,
   input  logic                rst,
   input  slot_e               slot,
   input  logic                armed,
   input  logic [BRANCHES-1:0] br_bit,
   output logic                rf_out
);

   logic [1:0]          slot_v;
   logic [BRANCHES-1:0] chop;
   logic                pick;

   assign slot_v = slot;

   // Per-branch chopper: true bit in the first half period, inverted in the second.
   generate
      for (genvar b = 0; b < BRANCHES; b++) begin : g_chop
         assign chop[b] = br_bit[b] ^ slot_v[1];
      end
   endgenerate

   // Combining selector alternates branches every fast clock.
   assign pick = chop[slot_v[0]];

   always_ff @(posedge clk) begin
      if (rst) rf_out <= 1'b0;
      else     rf_out <= armed & pick;
   end

endmodule

// File: rtl/dsm_iq_tx.sv
module dsm_iq_tx
   import dsm_iq_pkg::*;
#(
   parameter int unsigned IN_W   = 16,
   parameter int unsigned ACC_W  = 20,
   parameter int unsigned N_MAX  = 64,
   parameter int unsigned N_W    = 7,
   parameter bit          SAT_EN = 1'b1
)(
   input  logic                   clk,
   input  logic                   rst,
   input  logic signed [IN_W-1:0] i_smp,
   input  logic signed [IN_W-1:0] q_smp,
   input  logic                   smp_vld,
   input  logic [N_W-1:0]         ratio_n,
   output logic                   smp_stb,
   output logic                   rf_out
);

   slot_e                   slot_idx;
   logic                    car_end;
   logic                    smp_bnd;
   logic [N_W-1:0]          n_cur;
   logic signed [IN_W-1:0]  hold_i, hold_q;
   logic                    armed_q;
   logic [BRANCHES-1:0]     br_bit;
   logic signed [IN_W-1:0]  br_x [BRANCHES];

   dsm_iq_seq #(
      .N_MAX (N_MAX),
      .N_W   (N_W)
   ) u_seq (
      .clk     (clk),
      .rst     (rst),
      .ratio_n (ratio_n),
      .slot    (slot_idx),
      .car_end (car_end),
      .smp_bnd (smp_bnd),
      .n_cur   (n_cur)
   );

   assign smp_stb = smp_bnd;

   // Sample capture at the boundary; held for N carrier periods.
   always_ff @(posedge clk) begin
      if (rst) begin
         hold_i  <= '0;
         hold_q  <= '0;
         armed_q <= 1'b0;
      end else if (smp_bnd && smp_vld) begin
         hold_i  <= i_smp;
         hold_q  <= q_smp;
         armed_q <= 1'b1;
      end
   end

   assign br_x[0] = hold_i;
   assign br_x[1] = hold_q;

   generate
      for (genvar b = 0; b < BRANCHES; b++) begin : g_branch
         dsm_iq_mod #(
            .IN_W   (IN_W),
            .ACC_W  (ACC_W),
            .SAT_EN (SAT_EN)
         ) u_mod (
            .clk   (clk),
            .rst   (rst),
            .step  (car_end & armed_q),
            .x     (br_x[b]),
            .bit_q (br_bit[b])
         );
      end
   endgenerate

   dsm_iq_mux u_mux (
      .clk    (clk),
      .rst    (rst),
      .slot   (slot_idx),
      .armed  (armed_q),
      .br_bit (br_bit),
      .rf_out (rf_out)
   );

endmodule

// File: rtl/dsm_iq_tx_chk.sv
module dsm_iq_tx_chk #(
   parameter int unsigned IN_W  = 16,
   parameter int unsigned N_MAX = 64,
   parameter int unsigned N_W   = 7
)(
   input logic                   clk,
   input logic                   rst,
   input logic                   smp_stb,
   input logic                   smp_vld,
   input logic                   rf_out,
   input logic [1:0]             slot_v,
   input logic                   armed,
   input logic [N_W-1:0]         n_cur,
   input logic signed [IN_W-1:0] hold_i
);

   // R1
   idle_low_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(armed) |-> !rf_out);

   // R5
   ibar_inv_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_v == 2'd3 && $past(armed, 2)) |-> (rf_out != $past(rf_out, 2)));

   // R5
   qbar_inv_chk: assert property (@(posedge clk) disable iff (rst)
      (slot_v == 2'd0 && $past(armed, 2)) |-> (rf_out != $past(rf_out, 2)));

   // R2
   stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      smp_stb |=> !smp_stb);

   // R3
   n_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(n_cur) |-> $past(smp_stb));

   // R4
   n_range_chk: assert property (@(posedge clk) disable iff (rst)
      (n_cur >= N_W'(1)) && (n_cur <= N_W'(N_MAX)));

   // R6
   hold_cap_chk: assert property (@(posedge clk) disable iff (rst)
      !$stable(hold_i) |-> $past(smp_stb && smp_vld));

endmodule

bind dsm_iq_tx dsm_iq_tx_chk #(
   .IN_W  (IN_W),
   .N_MAX (N_MAX),
   .N_W   (N_W)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .smp_stb (smp_stb),
   .smp_vld (smp_vld),
   .rf_out  (rf_out),
   .slot_v  (slot_idx),
   .armed   (armed_q),
   .n_cur   (n_cur),
   .hold_i  (hold_i)
);

// File: tb/dsm_iq_tx_bench.sv
module dsm_iq_tx_bench;

   logic               clk = 1'b0;
   logic               rst;
   logic signed [15:0] i_smp, q_smp;
   logic               smp_vld;
   logic [6:0]         ratio_n;
   logic               smp_stb, rf_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   localparam int SETTLE = 100;
   localparam int MWIN   = 3000;
   localparam int TOL    = 328;

   always #2 clk = ~clk;

   dsm_iq_tx u_dsm_iq_tx (
      .clk     (clk),
      .rst     (rst),
      .i_smp   (i_smp),
      .q_smp   (q_smp),
      .smp_vld (smp_vld),
      .ratio_n (ratio_n),
      .smp_stb (smp_stb),
      .rf_out  (rf_out)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint absl(input longint v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic wait_stb();
      do @(negedge clk); while (!smp_stb);
   endtask

   task automatic gap(output int g);
      wait_stb();
      g = 0;
      do begin @(negedge clk); g++; end while (!smp_stb);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   // Demodulate I and Q bits per carrier period; optionally toggle inputs
   // so that only the strobe clock presents (bi,bq).
   task automatic measure(input bit tog,
                          input logic signed [15:0] ai, input logic signed [15:0] aq,
                          input logic signed [15:0] bi, input logic signed [15:0] bq,
                          output longint mi, output longint mq,
                          output int ones_i, output int bad);
      int  slot_n;
      int  per;
      int  ones_q;
      bit  r0, r1;
      r0 = 1'b0; r1 = 1'b0;
      ones_i = 0; ones_q = 0; bad = 0; per = 0;
      do begin
         @(negedge clk);
         if (tog) begin
            if (smp_stb) begin i_smp = bi; q_smp = bq; end
            else         begin i_smp = ai; q_smp = aq; end
         end
      end while (!smp_stb);
      @(negedge clk);
      if (tog) begin i_smp = ai; q_smp = aq; end
      slot_n = 3;
      while (per < SETTLE + MWIN) begin
         @(negedge clk);
         if (tog) begin
            if (smp_stb) begin i_smp = bi; q_smp = bq; end
            else         begin i_smp = ai; q_smp = aq; end
         end
         slot_n = (slot_n + 1) % 4;
         case (slot_n)
            0: r0 = rf_out;
            1: r1 = rf_out;
            2: if (rf_out == r0) bad++;
            default: begin
               if (rf_out == r1) bad++;
               if (per >= SETTLE) begin
                  ones_i += int'(r0);
                  ones_q += int'(r1);
               end
               per++;
            end
         endcase
      end
      mi = ((2 * longint'(ones_i) - MWIN) * 32768) / MWIN;
      mq = ((2 * longint'(ones_q) - MWIN) * 32768) / MWIN;
   endtask

   task automatic mean_case(input string tag, input logic signed [15:0] xi,
                            input logic signed [15:0] xq, input bit vld,
                            input logic signed [15:0] expi, input logic signed [15:0] expq);
      longint mi, mq;
      int     oi, bad;
      i_smp = xi; q_smp = xq; smp_vld = vld;
      measure(1'b0, xi, xq, xi, xq, mi, mq, oi, bad);
      chk(absl(mi - expi) <= TOL, {tag, " R7 I mean"}, mi, expi);
      chk(absl(mq - expq) <= TOL, {tag, " R8 Q mean"}, mq, expq);
      chk(bad == 0, {tag, " R5 slot pattern"}, bad, 0);
   endtask

   initial begin
      int g, c, nz, ns;
      longint mi, mq;
      int oi, bad;
      rst = 1'b1; i_smp = '0; q_smp = '0; smp_vld = 1'b0; ratio_n = 7'd1;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(rf_out == 1'b0, "R1 rf_out in reset", rf_out, 0);
      chk(smp_stb == 1'b0, "R1 smp_stb in reset", smp_stb, 0);
      rst = 1'b0;

      // R1 output idle before first valid capture; R2 strobe count at N=1
      nz = 0; ns = 0;
      repeat (40) begin
         @(negedge clk);
         if (rf_out) nz++;
         if (smp_stb) ns++;
      end
      chk(nz == 0, "R1 idle output before valid", nz, 0);
      chk(ns == 10, "R2 strobes in 40 clocks N=1", ns, 10);

      // R2 intervals
      ratio_n = 7'd3;   gap(g); chk(g == 12,  "R2 interval N=3",  g, 12);
      ratio_n = 7'd64;  gap(g); chk(g == 256, "R2 interval N=64", g, 256);
      // R4 clamping
      ratio_n = 7'd0;   gap(g); chk(g == 4,   "R4 ratio 0 as 1",  g, 4);
      ratio_n = 7'd100; gap(g); chk(g == 256, "R4 ratio 100 as 64", g, 256);

      // R3 change mid-interval
      ratio_n = 7'd3; gap(g);
      c = 0;
      repeat (2) begin @(negedge clk); c++; end
      ratio_n = 7'd5;
      do begin @(negedge clk); c++; end while (!smp_stb);
      chk(c == 12, "R3 running interval unchanged", c, 12);
      c = 0;
      do begin @(negedge clk); c++; end while (!smp_stb);
      chk(c == 20, "R3 new ratio after boundary", c, 20);

      ratio_n = 7'd1;
      wait_stb(); wait_stb();

      // R7 / R8 / R5 mean tracking
      mean_case("zero",  16'sd0,      16'sd0,      1'b1, 16'sd0,      16'sd0);
      mean_case("half",  16'sd16384,  -16'sd16384, 1'b1, 16'sd16384,  -16'sd16384);
      mean_case("mixed", -16'sd8000,  16'sd12000,  1'b1, -16'sd8000,  16'sd12000);
      // R6 invalid inputs ignored
      mean_case("R6 vld low", -16'sd16000, 16'sd3000, 1'b0, -16'sd8000, 16'sd12000);

      // R9 most negative code from clean state
      do_reset();
      ratio_n = 7'd1; smp_vld = 1'b1; i_smp = -16'sd32768; q_smp = 16'sd5000;
      measure(1'b0, i_smp, q_smp, i_smp, q_smp, mi, mq, oi, bad);
      chk(oi == 0, "R9 I bits at most negative code", oi, 0);
      chk(absl(mq - 5000) <= TOL, "R8 Q mean beside saturated I", mq, 5000);
      chk(bad == 0, "R5 slot pattern at extreme", bad, 0);

      // R6 capture only at the strobe clock, N=4
      ratio_n = 7'd4; smp_vld = 1'b1;
      measure(1'b1, -16'sd15000, -16'sd15000, 16'sd10000, 16'sd4000, mi, mq, oi, bad);
      chk(absl(mi - 10000) <= TOL, "R6 I only strobe value held", mi, 10000);
      chk(absl(mq - 4000) <= TOL,  "R6 Q only strobe value held", mq, 4000);
      chk(bad == 0, "R5 slot pattern N=4", bad, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual %0d expected %0d", 1, 0);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule